// File: doc/BRIEF.md
# Two-Wire Serial Bus Control and Status Register

This block holds the control and status byte of a clocked two-wire serial bus port, together with the logic that acts on it. Software writes one-shot bits that move the serial-out latch high (a bus release) or low (a command). Software can also request an acknowledge bit, which goes out on the next falling edge of the serial clock. Other logic in the block watches the bus itself. Once the clock and data lines have passed a two-flop synchroniser, a rising data edge while the clock is high counts as a release. A falling data edge while the clock is high counts as a command. Each of these events sets a read-only flag.

Each flag has its own clear events: a transfer start, an address mismatch, a release detected on the bus, or dropping the interface enable. When a set and a clear fall in the same cycle, the clear wins. The shift register, the address comparator and the baud generator sit outside the block. They reach it only through the strobe and enable inputs.

Top module: `sbus_ctl`

## Requirements
- R1: After reset, rd_data is 8'h00, so_latch is 1 and ack_drive is 0.
- R2: The register layout, from bit 7 down to bit 0, is: busy enable (R/W), ack seen (read-only), ack watch enable (R/W), ack request, command seen (read-only), release seen (read-only), command request, release request. CPU writes leave bits 6, 3 and 2 unchanged, and bits 7 and 5 read back exactly what was written.
- R3: A write with bit 0 set while if_en is high makes bit 0 read 1 for exactly one cycle. In the following cycle so_latch becomes 1 and bit 0 reads 0.
- R4: A write with bit 1 set while if_en is high makes bit 1 read 1 for one cycle, and so_latch becomes 0 one cycle later. If bits 0 and 1 are written together, so_latch becomes 1.
- R5: While if_en is low, bits 6, 4, 3, 2, 1 and 0 read 0 one cycle later, ack_drive is 0, and writes to bits 4, 1 and 0 have no effect.
- R6: A rising edge of sdat_in while sclk_in is high sets bit 2 within five clock cycles.
- R7: Bit 2 is cleared by xfer_start, by addr_miss or by if_en low, and a clear overrides a set in the same cycle.
- R8: A falling edge of sdat_in while sclk_in is high sets bit 3. Bit 3 is cleared by xfer_start, by a detected release or by if_en low.
- R9: After bit 4 is written to 1, the next falling edge of sclk_in raises ack_drive (data line pulled low), and bit 4 clears at that point. ack_drive stays high until the following falling edge of sclk_in.
- R10: xfer_start clears bit 4, and with it any acknowledge still pending.
- R11: With bit 5 set and ack_drive low, a rising edge of sclk_in while sdat_in is low sets bit 6. Bit 6 is cleared by xfer_start or by if_en low.
- R12: so_latch changes only in the cycle after bit 0 or bit 1 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value |
| if_en | input | 1 | Interface enable |
| xfer_start | input | 1 | Transfer-start strobe |
| addr_miss | input | 1 | Address mismatch pulse during address reception |
| sclk_in | input | 1 | Serial clock line (asynchronous) |
| sdat_in | input | 1 | Serial data line (asynchronous) |
| so_latch | output | 1 | Serial-out latch value |
| ack_drive | output | 1 | Pull the data line low for the acknowledge |

## Verification
The assertions check on every cycle the cycle-level rules of the block. They cover the one-shot life of the release and command bits, the moves of so_latch that follow those bits and no others, the clears caused by the transfer strobe, the address mismatch and the interface disable, and the silencing of ack_drive while the port is off. Other behaviour passes through the line synchroniser and is measured in serial-clock periods, so only the bench scenarios can show it. This covers bus-condition detection, the cancelling of a command flag by a later release, the acknowledge timing from one falling clock edge to the next, the ack-seen flag, and the rule that read-only bits ignore writes.

// File: rtl/sbus_ctl.sv
module sbus_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       if_en,
  input  logic       xfer_start,
  input  logic       addr_miss,
  input  logic       sclk_in,
  input  logic       sdat_in,
  output logic       so_latch,
  output logic       ack_drive
);
  logic [1:0] sclk_sync, sdat_sync;
  logic       sclk_d, sdat_d;
  logic       busy_en, ack_seen, ack_watch, ack_req;
  logic       cmd_seen, rel_seen, cmd_req, rel_req;

  wire sclk_s    = sclk_sync[1];
  wire sdat_s    = sdat_sync[1];
  wire sclk_fall = sclk_d & ~sclk_s;
  wire sclk_rise = ~sclk_d & sclk_s;
  wire rel_det   = if_en & sclk_s & sclk_d & sdat_s & ~sdat_d;
  wire cmd_det   = if_en & sclk_s & sclk_d & ~sdat_s & sdat_d;

  assign rd_data = {busy_en, ack_seen, ack_watch, ack_req,
                    cmd_seen, rel_seen, cmd_req, rel_req};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sync <= 2'b11;
      sdat_sync <= 2'b11;
      sclk_d    <= 1'b1;
      sdat_d    <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[0], sclk_in};
      sdat_sync <= {sdat_sync[0], sdat_in};
      sclk_d    <= sclk_s;
      sdat_d    <= sdat_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_en   <= 1'b0;
      ack_watch <= 1'b0;
      rel_req   <= 1'b0;
      cmd_req   <= 1'b0;
      so_latch  <= 1'b1;
    end else begin
      if (wr_en) begin
        busy_en   <= wr_data[7];
        ack_watch <= wr_data[5];
      end
      rel_req <= if_en & wr_en & wr_data[0] & ~rel_req;
      cmd_req <= if_en & wr_en & wr_data[1] & ~cmd_req;
      if (rel_req)      so_latch <= 1'b1;
      else if (cmd_req) so_latch <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_req   <= 1'b0;
      ack_drive <= 1'b0;
    end else begin
      if (!if_en || xfer_start)    ack_req <= 1'b0;
      else if (sclk_fall && ack_req) ack_req <= 1'b0;
      else if (wr_en)              ack_req <= wr_data[4];

      if (!if_en)         ack_drive <= 1'b0;
      else if (sclk_fall) ack_drive <= ack_req & ~xfer_start;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_seen <= 1'b0;
      cmd_seen <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      if (!if_en || xfer_start || addr_miss) rel_seen <= 1'b0;
      else if (rel_det)                      rel_seen <= 1'b1;

      if (!if_en || xfer_start || rel_det) cmd_seen <= 1'b0;
      else if (cmd_det)                    cmd_seen <= 1'b1;

      if (!if_en || xfer_start) ack_seen <= 1'b0;
      else if (sclk_rise && !sdat_s && ack_watch && !ack_drive) ack_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/sbus_ctl_chk.sv
module sbus_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       if_en,
  input logic       xfer_start,
  input logic       addr_miss,
  input logic       so_latch,
  input logic       ack_drive
);
  AST_REL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |=> (!rd_data[0] && so_latch)); // R3
  AST_CMD_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && !rd_data[0]) |=> (!rd_data[1] && !so_latch)); // R4
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> (rd_data[6:0] & 7'h5F) == 7'h00); // R5
  AST_DISABLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> !ack_drive); // R5
  AST_MISS_CLEARS_REL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !rd_data[2]); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (!rd_data[2] && !rd_data[3] && !rd_data[6])); // R8
  AST_START_DROPS_ACKREQ: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !rd_data[4]); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[0] && !rd_data[1]) |=> $stable(so_latch)); // R12
endmodule

bind sbus_ctl sbus_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .if_en(if_en),
  .xfer_start(xfer_start), .addr_miss(addr_miss),
  .so_latch(so_latch), .ack_drive(ack_drive)
);

// File: tb/sbus_ctl_tb_top.sv
module sbus_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic if_en = 1'b1, xfer_start = 1'b0, addr_miss = 1'b0;
  logic sclk_in = 1'b1, sdat_in = 1'b1;
  logic so_latch, ack_drive;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sbus_ctl dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 so_latch", so_latch, 1);
    chk("R1 ack_drive", ack_drive, 0);
  endtask

  task automatic t_rw_bits();
    wr(8'hEC);
    chk("R2 rw bits 7,5 kept, ro 6,3,2 ignored", rd_data & 8'hEC, 8'hA0);
    wr(8'h00);
    chk("R2 clear", rd_data, 8'h00);
  endtask

  task automatic t_cmd_out();
    wr(8'h02);
    chk("R4 cmd bit visible", rd_data[1], 1);
    chk("R4 latch not yet", so_latch, 1);
    cyc(1);
    chk("R4 latch low", so_latch, 0);
    chk("R4 cmd bit self-clears", rd_data[1], 0);
    cyc(3);
    chk("R12 latch holds", so_latch, 0);
  endtask

  task automatic t_rel_out();
    wr(8'h01);
    chk("R3 rel bit visible", rd_data[0], 1);
    chk("R3 latch not yet", so_latch, 0);
    cyc(1);
    chk("R3 latch high", so_latch, 1);
    chk("R3 rel bit self-clears", rd_data[0], 0);
    wr(8'h02); cyc(1);
    wr(8'h03); cyc(1);
    chk("R4 both written: release wins", so_latch, 1);
  endtask

  task automatic t_disable();
    wr(8'h02); cyc(1);
    if_en = 1'b0;
    wr(8'h13);
    cyc(2);
    chk("R5 writes ignored while disabled", rd_data & 8'h13, 8'h00);
    chk("R5 latch untouched", so_latch, 0);
    if_en = 1'b1;
    wr(8'h01); cyc(1);
  endtask

  task automatic t_rel_detect();
    sclk_in = 1'b0; cyc(4);
    sdat_in = 1'b0; cyc(4);
    sclk_in = 1'b1; cyc(4);
    chk("R8 no command when data fell with clock low", rd_data[3], 0);
    sdat_in = 1'b1; cyc(5);
    chk("R6 release seen", rd_data[2], 1);
    wr(8'h00);
    chk("R2 write does not clear ro bit", rd_data[2], 1);
    pulse_start();
    chk("R7 transfer start clears", rd_data[2], 0);
    sdat_in = 1'b0; cyc(4); sdat_in = 1'b1; cyc(5);
    chk("R6 release seen again", rd_data[2], 1);
    addr_miss = 1'b1; @(negedge clk); addr_miss = 1'b0;
    chk("R7 address miss clears", rd_data[2], 0);
    sdat_in = 1'b0; cyc(4); sdat_in = 1'b1; cyc(5);
    if_en = 1'b0; cyc(1);
    chk("R7 disable clears", rd_data[2], 0);
    if_en = 1'b1; cyc(1);
  endtask

  task automatic t_cmd_detect();
    sdat_in = 1'b0; cyc(5);
    chk("R8 command seen", rd_data[3], 1);
    sdat_in = 1'b1; cyc(5);
    chk("R8 release clears command", rd_data[3], 0);
    chk("R6 release on same edge", rd_data[2], 1);
    sdat_in = 1'b0; cyc(5);
    pulse_start();
    chk("R8 transfer start clears", rd_data[3], 0);
    sdat_in = 1'b1; cyc(5);
    pulse_start();
  endtask

  task automatic t_ack_out();
    wr(8'h10);
    chk("R9 ack request held", rd_data[4], 1);
    cyc(3);
    chk("R9 no ack before falling edge", ack_drive, 0);
    sclk_in = 1'b0; cyc(5);
    chk("R9 ack driven", ack_drive, 1);
    chk("R9 request self-clears", rd_data[4], 0);
    sclk_in = 1'b1; cyc(5);
    chk("R9 ack held through high phase", ack_drive, 1);
    sclk_in = 1'b0; cyc(5);
    chk("R9 ack ends on next fall", ack_drive, 0);
    sclk_in = 1'b1; cyc(4);
    wr(8'h10);
    pulse_start();
    chk("R10 start clears request", rd_data[4], 0);
    sclk_in = 1'b0; cyc(5);
    chk("R10 no ack after cancel", ack_drive, 0);
  endtask

  task automatic t_ack_detect();
    wr(8'h20);
    sdat_in = 1'b0; cyc(4);
    sclk_in = 1'b1; cyc(5);
    chk("R11 ack seen", rd_data[6], 1);
    wr(8'h20);
    chk("R2 write does not clear ack seen", rd_data[6], 1);
    pulse_start();
    chk("R11 start clears", rd_data[6], 0);
    wr(8'h00);
    sclk_in = 1'b0; cyc(4); sclk_in = 1'b1; cyc(5);
    chk("R11 no set without watch enable", rd_data[6], 0);
    sdat_in = 1'b1; cyc(5);
    pulse_start();
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_rw_bits();
    t_cmd_out();
    t_rel_out();
    t_disable();
    t_rel_detect();
    t_cmd_detect();
    t_ack_out();
    t_ack_detect();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule